// File: doc/BRIEF.md
# Load-Aware Thermal Shutdown Arbiter

This block chooses which regulator channels to switch off when the die overheats. An over-temperature flag starts a hold period. At the moment of the trip, the block records which channels carry a heavy load (more than 50 mA) and disables only those. Lightly loaded channels keep regulating.

The disabled set stays fixed until a separate cooled flag reports that the die has dropped below the lower threshold. This gives a hysteresis band between the two flags. On release, each disabled channel receives a one-cycle soft-start restart request, unless its own sequencer turn-on signal dropped while it was held off.

The per-channel pass-device enable it drives is the sequencer turn-on combined with the thermal disable. Sensing of temperature and current happens outside the block.

Top module: `thermal_arbiter`

## Requirements
- R1: While reset is applied, and after it, before any trip, `therm_off` and `restart_req` are all zero and `pass_en` equals `seq_on`.
- R2: On the first clock edge where `over_temp` is high and no hold is active, a hold starts and `therm_off` takes the value of `heavy_load` (bit i is channel i). It is visible after that edge.
- R3: A channel whose `therm_off` bit is clear keeps `pass_en` equal to its `seq_on`. A channel whose `therm_off` bit is set has `pass_en` low.
- R4: During a hold, `therm_off` does not change when `heavy_load` changes. A channel that was disabled stays disabled after its load flag falls.
- R5: A trip with no heavy channel disables nothing but still starts a hold. Heavy loads that appear later in that hold disable nothing.
- R6: A hold ends only on an edge where `cooled` is high and `over_temp` is low. `cooled` has no effect outside a hold.
- R7: On the edge that ends a hold, `therm_off` clears. `restart_req` is high for exactly one cycle on each channel that was disabled.
- R8: A disabled channel whose `seq_on` was low on any edge during the hold receives no restart request.
- R9: `over_temp` staying or rising again during a hold does not recapture the disabled set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| over_temp | input | 1 | Die over-temperature trip flag |
| cooled | input | 1 | Die has cooled below the release threshold |
| heavy_load | input | NCH | Per-channel load above 50 mA |
| seq_on | input | NCH | Per-channel turn-on from the enable sequencer |
| therm_off | output | NCH | Per-channel thermal disable |
| restart_req | output | NCH | Per-channel one-cycle soft-start request |
| pass_en | output | NCH | Per-channel pass-device enable |

## Verification
The hardest case to reach is a channel that is held off and then loses its sequencer turn-on part-way through the hold. The stimulus must trip with both channels heavy, drop one turn-on for a single cycle, restore it, and only then release. Only the silent restart slot shows whether that one cycle was remembered. The bench also reaches the empty hold: a trip with no heavy load, followed by heavy loads while still hot. This shows that the hold exists even though no output moved.

// File: rtl/thermal_arbiter_pkg.sv
package thermal_arbiter_pkg;
  typedef enum logic {
    ST_COOL = 1'b0,
    ST_HOT  = 1'b1
  } therm_state_t;
endpackage

// File: rtl/thermal_hold_fsm.sv
module thermal_hold_fsm
  import thermal_arbiter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic over_temp,
  input  logic cooled,
  output logic trip_evt,
  output logic rel_evt,
  output logic hold_act
);
  therm_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    trip_evt = 1'b0;
    rel_evt  = 1'b0;
    case (state_q)
      ST_COOL: if (over_temp) begin
        trip_evt = 1'b1;
        state_d  = ST_HOT;
      end
      ST_HOT: if (cooled && !over_temp) begin
        rel_evt = 1'b1;
        state_d = ST_COOL;
      end
      default: state_d = ST_COOL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_COOL;
    else        state_q <= state_d;
  end

  assign hold_act = (state_q == ST_HOT);

  // R6
  release_needs_cool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_act) |-> ($past(cooled) && !$past(over_temp)));
  // R2
  hold_starts_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_act) |-> $past(over_temp));
endmodule

// File: rtl/thermal_chan_cell.sv
module thermal_chan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_evt,
  input  logic rel_evt,
  input  logic hold_act,
  input  logic heavy,
  input  logic seq_on,
  output logic off,
  output logic restart
);
  logic off_q, off_d;
  logic arm_q, arm_d;
  logic rst_q, rst_d;

  always_comb begin
    off_d = off_q;
    arm_d = arm_q;
    rst_d = 1'b0;
    if (trip_evt) begin
      off_d = heavy;
      arm_d = heavy & seq_on;
    end else if (rel_evt) begin
      off_d = 1'b0;
      arm_d = 1'b0;
      rst_d = arm_q & seq_on;
    end else if (hold_act && !seq_on) begin
      arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= 1'b0;
      arm_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      off_q <= off_d;
      arm_q <= arm_d;
      rst_q <= rst_d;
    end
  end

  assign off     = off_q;
  assign restart = rst_q;

  // R7
  restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);
  // R7
  restart_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> ($past(off) && !off));
  // R4
  off_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold_act) && hold_act) |-> $stable(off));
  // R8
  no_restart_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !seq_on) |=> !restart);
endmodule

// File: rtl/thermal_arbiter.sv
module thermal_arbiter #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           over_temp,
  input  logic           cooled,
  input  logic [NCH-1:0] heavy_load,
  input  logic [NCH-1:0] seq_on,
  output logic [NCH-1:0] therm_off,
  output logic [NCH-1:0] restart_req,
  output logic [NCH-1:0] pass_en
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       trip_evt, rel_evt, hold_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_n & rst_sync_q[1];

  thermal_hold_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .over_temp (over_temp),
    .cooled    (cooled),
    .trip_evt  (trip_evt),
    .rel_evt   (rel_evt),
    .hold_act  (hold_act)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    thermal_chan_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .trip_evt (trip_evt),
      .rel_evt  (rel_evt),
      .hold_act (hold_act),
      .heavy    (heavy_load[i]),
      .seq_on   (seq_on[i]),
      .off      (therm_off[i]),
      .restart  (restart_req[i])
    );
  end

  assign pass_en = seq_on & ~therm_off;

  // R9
  no_recapture_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(hold_act) && hold_act) |-> $stable(therm_off));
  // R5
  off_subset_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|therm_off) |-> hold_act);
endmodule

// File: tb/thermal_arbiter_test.sv
module thermal_arbiter_test;
  localparam int NCH = 2;
  localparam int NV  = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic over_temp = 1'b0, cooled = 1'b0;
  logic [NCH-1:0] heavy_load = '0, seq_on = '0;
  logic [NCH-1:0] therm_off, restart_req, pass_en;

  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  thermal_arbiter #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .over_temp(over_temp), .cooled(cooled),
    .heavy_load(heavy_load), .seq_on(seq_on),
    .therm_off(therm_off), .restart_req(restart_req), .pass_en(pass_en)
  );

  // {over_temp, cooled, heavy[1:0], seq[1:0], exp_off[1:0], exp_restart[1:0]}
  localparam logic [9:0] VECS [NV] = '{
    10'b0_0_00_11_00_00, // 0  R1 idle
    10'b0_1_00_11_00_00, // 1  R6 cooled outside hold
    10'b1_0_01_11_01_00, // 2  R2 R3 trip, ch0 heavy
    10'b1_0_11_11_01_00, // 3  R9 no recapture
    10'b0_0_00_11_01_00, // 4  R4 load drop keeps off
    10'b1_1_00_11_01_00, // 5  R6 blocked while hot
    10'b0_1_00_11_00_01, // 6  R7 release + restart
    10'b0_0_00_11_00_00, // 7  R7 single pulse
    10'b1_0_11_11_11_00, // 8  R2 both heavy
    10'b0_0_11_01_11_00, // 9  R8 ch1 turn-on drops
    10'b0_0_11_11_11_00, // 10 R8 restored
    10'b0_1_00_11_00_01, // 11 R8 only ch0 restarts
    10'b0_0_00_11_00_00, // 12 R7
    10'b1_0_00_11_00_00, // 13 R5 empty trip
    10'b1_0_11_11_00_00, // 14 R5 hold, no capture
    10'b0_1_00_11_00_00, // 15 R5 release, nothing
    10'b1_0_10_11_10_00, // 16 R2 R3 ch1 only
    10'b0_1_00_11_00_10  // 17 R7 ch1 restart
  };

  function automatic string vec_tag(int k);
    case (k)
      0: return "R1";
      1, 5: return "R6";
      2, 8, 16: return "R2";
      3: return "R9";
      4: return "R4";
      9, 10, 11: return "R8";
      13, 14, 15: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    seq_on = 2'b11;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", therm_off, 2'b00, "therm_off in reset");
    check("R1", restart_req, 2'b00, "restart_req in reset");
    check("R3", pass_en, 2'b11, "pass_en in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [9:0] v;
      v = VECS[k];
      over_temp  = v[9];
      cooled     = v[8];
      heavy_load = v[7:6];
      seq_on     = v[5:4];
      @(negedge clk);
      check(vec_tag(k), therm_off, v[3:2], "therm_off");
      check(vec_tag(k), restart_req, v[1:0], "restart_req");
      check("R3", pass_en, v[5:4] & ~v[3:2], "pass_en");
    end

    // R1: reset in the middle of a hold clears everything, no restart later
    over_temp = 1'b1; cooled = 1'b0; heavy_load = 2'b11; seq_on = 2'b11;
    @(negedge clk);
    over_temp = 1'b0; heavy_load = 2'b00;
    check("R2", therm_off, 2'b11, "therm_off before reset");
    rst_n = 1'b0;
    #1;
    check("R1", therm_off, 2'b00, "therm_off async reset");
    check("R3", pass_en, 2'b11, "pass_en async reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cooled = 1'b1;
    @(negedge clk);
    check("R6", restart_req, 2'b00, "restart after reset");
    check("R6", therm_off, 2'b00, "therm_off after reset");
    cooled = 1'b0;

    // R4/R7: long hold, restart exactly one cycle wide
    over_temp = 1'b1; heavy_load = 2'b10;
    @(negedge clk);
    over_temp = 1'b0; heavy_load = 2'b00;
    repeat (20) @(negedge clk);
    check("R4", therm_off, 2'b10, "therm_off long hold");
    cooled = 1'b1;
    @(negedge clk);
    check("R7", restart_req, 2'b10, "restart pulse");
    @(negedge clk);
    check("R7", restart_req, 2'b00, "restart pulse end");
    cooled = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule